// File: doc/BRIEF.md
# Flexible Disk Spindle and Media-Change Supervisor

This block looks after up to four flexible disk drives on behalf of a disk controller. It keeps the spindle motors and head-load lines up while drives are in use. For each drive it counts idle time with its own counter, and it drops the motor or unloads the head once that count runs out. Two strap inputs pick one of three operating styles. Each style decides three things: whether the controller sees a permanently asserted ready or the ready line of the selected drive, whether the timeout stops the motor or only lifts the head, and whether media changes are watched for.

Any command that addresses a drive pulses the activity strobe with that drive on the select lines. This reloads that drive's idle counter and wakes its outputs at once, even if the drive had already timed out. In the styles that watch for media changes, the block samples every drive's ready line at a fixed interval. A ready line found high after a stored low sample counts as a media change. The block then raises a recalibrate request for that drive and a host interrupt. Both stay up until they are acknowledged.

Top module: `fdd_spindle_supervisor`

## Requirements
- R1: The straps `cfg_a`/`cfg_b` select the style: 1/1 = forced-ready, 1/0 = pass-ready, 0/0 = head-unload, and 0/1 behaves as head-unload.
- R2: `ctl_rdy` is 1 in forced-ready style. In the other styles it equals `drv_rdy[drv_sel]` in the same cycle.
- R3: When `act_stb` is high at a clock edge, the idle counter of drive `drv_sel` is reloaded to the full timeout for the current style. After that edge, that drive's `motor_on` and `head_load` are 1, whether or not the drive had timed out.
- R4: In forced-ready and pass-ready styles, a drive's `motor_on` and `head_load` are equal. Both fall after MOTOR_TICKS idle ticks (one tick every TICK_DIV cycles, counted from reset) with no further strobe for that drive.
- R5: In head-unload style, `motor_on` is all ones, and a drive's `head_load` falls after HEAD_TICKS idle ticks without a strobe for that drive.
- R6: Every SAMPLE_DIV cycles (counted from reset), each `drv_rdy` bit is sampled and stored. A change is a stored 0 followed by a sampled 1. After reset the stored value is 1.
- R7: In forced-ready style, no change is reported and neither `irq` nor any `recal_req` bit is set.
- R8: A change on drive i sets `recal_req[i]` and `irq` at the same edge that takes the sample.
- R9: `recal_ack[i]` clears `recal_req[i]`, and `irq_clr` clears `irq`. If a set and a clear occur in the same cycle, the set wins. Otherwise both stay asserted.
- R10: During reset all idle counters are zero, and `recal_req` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_a | input | 1 | First style strap |
| cfg_b | input | 1 | Second style strap |
| drv_sel | input | SEL_W (2) | Drive addressed by the controller |
| act_stb | input | 1 | One-cycle activity strobe for `drv_sel` |
| drv_rdy | input | NUM_DRIVES (4) | Ready line of each drive |
| recal_ack | input | NUM_DRIVES (4) | Per-drive clear of a recalibrate request |
| irq_clr | input | 1 | Clear of the host interrupt |
| motor_on | output | NUM_DRIVES (4) | Spindle motor enables |
| head_load | output | NUM_DRIVES (4) | Head-load enables |
| ctl_rdy | output | 1 | Ready presented to the disk controller |
| recal_req | output | NUM_DRIVES (4) | Pending recalibrate requests |
| irq | output | 1 | Host interrupt for a media change |

## Verification
`ctl_rdy` is combinational, so it is due in the same cycle as the straps, select and ready inputs. `motor_on` and `head_load` follow a strobe one edge later. They fall one edge after the tick that empties the counter. `recal_req` and `irq` appear one edge after the sample tick that sees the low-to-high change, and they clear one edge after an acknowledge. The bench changes inputs 2 ns after a rising edge. It steps its reference model on the rising edge from those settled inputs, and it compares every output on the falling edge, so each result is read in the cycle it is due.

// File: rtl/fdd_sup_pkg.sv
package fdd_sup_pkg;

    typedef enum logic [1:0] {
        STYLE_FORCED = 2'd0,
        STYLE_PASS   = 2'd1,
        STYLE_HEAD   = 2'd2
    } sup_style_e;

    typedef struct packed {
        logic spin;
        logic head;
    } spindle_t;

    function automatic sup_style_e decode_style(input logic a, input logic b);
        if (a && b)
            return STYLE_FORCED;
        else if (a)
            return STYLE_PASS;
        else
            return STYLE_HEAD;
    endfunction

    function automatic logic style_watches_media(input sup_style_e s);
        return s != STYLE_FORCED;
    endfunction

    function automatic spindle_t spindle_drive(input sup_style_e s, input logic busy);
        spindle_t r;
        r.spin = (s == STYLE_HEAD) ? 1'b1 : busy;
        r.head = busy;
        return r;
    endfunction

endpackage

// File: rtl/fdd_tick_gen.sv
module fdd_tick_gen #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/fdd_idle_timer.sv
module fdd_idle_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);
    logic [CNT_W-1:0] remain;

    assign busy = (remain != '0);

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (tick && busy)
            remain <= remain - 1'b1;
    end
endmodule

// File: rtl/fdd_change_detect.sv
module fdd_change_detect (
    input  logic clk,
    input  logic rst,
    input  logic sample,
    input  logic rdy,
    input  logic enable,
    input  logic ack,
    output logic change,
    output logic req
);
    logic last_rdy;

    assign change = sample && enable && !last_rdy && rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_rdy <= 1'b1;
            req      <= 1'b0;
        end else begin
            if (sample)
                last_rdy <= rdy;
            if (change)
                req <= 1'b1;
            else if (ack)
                req <= 1'b0;
        end
    end
endmodule

// File: rtl/fdd_spindle_supervisor.sv
module fdd_spindle_supervisor
    import fdd_sup_pkg::*;
#(
    parameter int NUM_DRIVES  = 4,
    parameter int TICK_DIV    = 100000,
    parameter int SAMPLE_DIV  = 1000000,
    parameter int MOTOR_TICKS = 4000,
    parameter int HEAD_TICKS  = 3000,
    localparam int SEL_W      = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_a,
    input  logic                  cfg_b,
    input  logic [SEL_W-1:0]      drv_sel,
    input  logic                  act_stb,
    input  logic [NUM_DRIVES-1:0] drv_rdy,
    input  logic [NUM_DRIVES-1:0] recal_ack,
    input  logic                  irq_clr,
    output logic [NUM_DRIVES-1:0] motor_on,
    output logic [NUM_DRIVES-1:0] head_load,
    output logic                  ctl_rdy,
    output logic [NUM_DRIVES-1:0] recal_req,
    output logic                  irq
);
    localparam int MAX_TICKS = (MOTOR_TICKS > HEAD_TICKS) ? MOTOR_TICKS : HEAD_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    sup_style_e             style;
    logic                   idle_tick;
    logic                   samp_tick;
    logic [CNT_W-1:0]       reload;
    logic [NUM_DRIVES-1:0]  busy;
    logic [NUM_DRIVES-1:0]  change;
    logic                   sel_ok;

    assign style  = decode_style(cfg_a, cfg_b);
    assign reload = (style == STYLE_HEAD) ? CNT_W'(HEAD_TICKS) : CNT_W'(MOTOR_TICKS);
    assign sel_ok = int'(drv_sel) < NUM_DRIVES;

    always_comb begin
        if (style == STYLE_FORCED)
            ctl_rdy = 1'b1;
        else
            ctl_rdy = sel_ok ? drv_rdy[drv_sel] : 1'b0;
    end

    fdd_tick_gen #(.DIV(TICK_DIV)) u_idle_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (idle_tick)
    );

    fdd_tick_gen #(.DIV(SAMPLE_DIV)) u_samp_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (samp_tick)
    );

    for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_drive
        spindle_t outs;

        fdd_idle_timer #(.CNT_W(CNT_W)) u_timer (
            .clk      (clk),
            .rst      (rst),
            .tick     (idle_tick),
            .load     (act_stb && sel_ok && (int'(drv_sel) == i)),
            .load_val (reload),
            .busy     (busy[i])
        );

        fdd_change_detect u_detect (
            .clk    (clk),
            .rst    (rst),
            .sample (samp_tick),
            .rdy    (drv_rdy[i]),
            .enable (style_watches_media(style)),
            .ack    (recal_ack[i]),
            .change (change[i]),
            .req    (recal_req[i])
        );

        assign outs         = spindle_drive(style, busy[i]);
        assign motor_on[i]  = outs.spin;
        assign head_load[i] = outs.head;
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else if (|change)
            irq <= 1'b1;
        else if (irq_clr)
            irq <= 1'b0;
    end
endmodule

// File: rtl/fdd_spindle_supervisor_chk.sv
module fdd_spindle_supervisor_chk #(
    parameter int NUM_DRIVES = 4,
    parameter int SEL_W      = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cfg_a,
    input logic                  cfg_b,
    input logic [SEL_W-1:0]      drv_sel,
    input logic                  act_stb,
    input logic [NUM_DRIVES-1:0] recal_ack,
    input logic                  irq_clr,
    input logic [NUM_DRIVES-1:0] motor_on,
    input logic [NUM_DRIVES-1:0] head_load,
    input logic                  ctl_rdy,
    input logic [NUM_DRIVES-1:0] recal_req,
    input logic                  irq
);
    AST_FORCED_READY: assert property (@(posedge clk) disable iff (rst)
        (cfg_a && cfg_b) |-> ctl_rdy); // R2

    AST_HEAD_STYLE_SPIN: assert property (@(posedge clk) disable iff (rst)
        !cfg_a |-> (motor_on == {NUM_DRIVES{1'b1}})); // R5

    AST_STROBE_WAKES: assert property (@(posedge clk) disable iff (rst)
        act_stb |=> (motor_on[$past(drv_sel)] && head_load[$past(drv_sel)])); // R3

    AST_NO_CHANGE_FORCED: assert property (@(posedge clk) disable iff (rst)
        (cfg_a && cfg_b && !irq) |=> !irq); // R7

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq); // R9

    AST_RECAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(recal_req) & ~$past(recal_ack) & ~recal_req) == '0)); // R9
endmodule

bind fdd_spindle_supervisor fdd_spindle_supervisor_chk #(
    .NUM_DRIVES (NUM_DRIVES),
    .SEL_W      (SEL_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_a     (cfg_a),
    .cfg_b     (cfg_b),
    .drv_sel   (drv_sel),
    .act_stb   (act_stb),
    .recal_ack (recal_ack),
    .irq_clr   (irq_clr),
    .motor_on  (motor_on),
    .head_load (head_load),
    .ctl_rdy   (ctl_rdy),
    .recal_req (recal_req),
    .irq       (irq)
);

// File: tb/fdd_spindle_supervisor_test.sv
module fdd_spindle_supervisor_test;
    localparam int ND = 4;
    localparam int TD = 4;
    localparam int SD = 3;
    localparam int MT = 5;
    localparam int HT = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_a = 1'b1, cfg_b = 1'b1;
    logic [1:0]    drv_sel = '0;
    logic          act_stb = 1'b0;
    logic [ND-1:0] drv_rdy = '1;
    logic [ND-1:0] recal_ack = '0;
    logic          irq_clr = 1'b0;
    logic [ND-1:0] motor_on, head_load, recal_req;
    logic          ctl_rdy, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fdd_spindle_supervisor #(
        .NUM_DRIVES(ND), .TICK_DIV(TD), .SAMPLE_DIV(SD),
        .MOTOR_TICKS(MT), .HEAD_TICKS(HT)
    ) uut (
        .clk(clk), .rst(rst), .cfg_a(cfg_a), .cfg_b(cfg_b), .drv_sel(drv_sel),
        .act_stb(act_stb), .drv_rdy(drv_rdy), .recal_ack(recal_ack), .irq_clr(irq_clr),
        .motor_on(motor_on), .head_load(head_load), .ctl_rdy(ctl_rdy),
        .recal_req(recal_req), .irq(irq)
    );

    // behavioural reference model
    int m_pc, m_sc;
    int m_tmr [ND];
    bit m_last [ND];
    bit m_req [ND];
    bit m_irq;

    function automatic int style_of(logic a, logic b);
        if (a && b) return 1;
        if (a) return 2;
        return 3;
    endfunction

    always @(posedge clk) begin
        int  st;
        bit  tk, sk, any;
        st = style_of(cfg_a, cfg_b);
        if (rst) begin
            m_pc = 0; m_sc = 0; m_irq = 0;
            for (int i = 0; i < ND; i++) begin
                m_tmr[i] = 0; m_last[i] = 1; m_req[i] = 0;
            end
        end else begin
            tk = (m_pc == TD - 1);
            sk = (m_sc == SD - 1);
            m_pc = tk ? 0 : m_pc + 1;
            m_sc = sk ? 0 : m_sc + 1;
            any = 0;
            for (int i = 0; i < ND; i++) begin
                bit ev;
                if (act_stb && int'(drv_sel) == i)
                    m_tmr[i] = (st == 3) ? HT : MT;
                else if (tk && m_tmr[i] > 0)
                    m_tmr[i] = m_tmr[i] - 1;
                ev = sk && st != 1 && !m_last[i] && drv_rdy[i];
                if (sk) m_last[i] = drv_rdy[i];
                if (ev) m_req[i] = 1;
                else if (recal_ack[i]) m_req[i] = 0;
                any |= ev;
            end
            if (any) m_irq = 1;
            else if (irq_clr) m_irq = 0;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic [ND-1:0] e_mot, e_head, e_req;
        int st;
        if (!rst && !done) begin
            st = style_of(cfg_a, cfg_b);
            for (int i = 0; i < ND; i++) begin
                e_head[i] = (m_tmr[i] != 0);
                e_mot[i]  = (st == 3) ? 1'b1 : e_head[i];
                e_req[i]  = m_req[i];
            end
            check("R4 motor_on", 32'(motor_on), 32'(e_mot));
            check("R5 head_load", 32'(head_load), 32'(e_head));
            check("R2 ctl_rdy", 32'(ctl_rdy), (st == 1) ? 32'd1 : 32'(drv_rdy[drv_sel]));
            check("R8 recal_req", 32'(recal_req), 32'(e_req));
            check("R9 irq", 32'(irq), 32'(m_irq));
        end
    end

    task automatic cyc(int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic strobe(int d);
        drv_sel = 2'(d);
        act_stb = 1'b1;
        cyc(1);
        act_stb = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        @(negedge clk);
        check("R10 irq after reset", 32'(irq), 0);
        check("R10 recal_req after reset", 32'(recal_req), 0);
        check("R10 motor_on after reset", 32'(motor_on), 0);
        cyc(1);
        rst = 1'b0;
        cyc(2);
        // forced style
        drv_rdy[0] = 1'b0; drv_sel = 2'd0;
        @(negedge clk);
        check("R2 forced ready ignores drive", 32'(ctl_rdy), 1);
        cyc(1);
        drv_rdy[0] = 1'b1;
        strobe(0);
        @(negedge clk);
        check("R3 strobe wakes drive0", 32'(motor_on[0]), 1);
        cyc(MT * TD + TD + 2);
        @(negedge clk);
        check("R4 motor off after timeout", 32'(motor_on[0]), 0);
        strobe(0);
        @(negedge clk);
        check("R3 rewake after timeout", 32'(motor_on[0]), 1);
        cyc(1);
        drv_rdy[1] = 1'b0; cyc(2 * SD);
        drv_rdy[1] = 1'b1; cyc(2 * SD);
        @(negedge clk);
        check("R7 no change in forced style", 32'(irq), 0);
        check("R7 no recal in forced style", 32'(recal_req), 0);
        cyc(1);
        // pass style
        cfg_b = 1'b0; drv_sel = 2'd1; drv_rdy[1] = 1'b0;
        @(negedge clk);
        check("R1 pass style forwards ready", 32'(ctl_rdy), 0);
        cyc(1);
        drv_rdy[1] = 1'b1;
        drv_rdy[2] = 1'b0; cyc(2 * SD + 1);
        drv_rdy[2] = 1'b1; cyc(2 * SD + 1);
        @(negedge clk);
        check("R6 change flags drive2", 32'(recal_req), 32'h4);
        check("R8 irq on change", 32'(irq), 1);
        cyc(1);
        recal_ack[2] = 1'b1; cyc(1); recal_ack[2] = 1'b0;
        @(negedge clk);
        check("R9 ack clears request", 32'(recal_req), 0);
        check("R9 irq held", 32'(irq), 1);
        cyc(1);
        irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
        @(negedge clk);
        check("R9 irq cleared", 32'(irq), 0);
        cyc(1);
        // head-unload style
        cfg_a = 1'b0;
        @(negedge clk);
        check("R5 spindles all on", 32'(motor_on), 32'hf);
        cyc(1);
        strobe(3);
        @(negedge clk);
        check("R5 head loaded", 32'(head_load[3]), 1);
        cyc(HT * TD + TD + 2);
        @(negedge clk);
        check("R5 head unloaded", 32'(head_load[3]), 0);
        check("R5 spindle stays on", 32'(motor_on), 32'hf);
        cyc(1);
        cfg_b = 1'b1;
        @(negedge clk);
        check("R1 strap 01 acts as head style", 32'(motor_on), 32'hf);
        cyc(1);
        // reset with ready high: stored value starts at 1
        cfg_a = 1'b1; cfg_b = 1'b0; rst = 1'b1; cyc(2); rst = 1'b0;
        cyc(4 * SD);
        @(negedge clk);
        check("R6 no change after reset with ready high", 32'(irq), 0);
        cyc(1);
        // mixed traffic compared every clock against the model
        for (int n = 0; n < 3000; n++) begin
            if (n % 200 == 0) begin
                cfg_a = 1'($urandom); cfg_b = 1'($urandom);
            end
            drv_sel   = 2'($urandom);
            act_stb   = ($urandom % 10) == 0;
            irq_clr   = ($urandom % 12) == 0;
            recal_ack = 4'($urandom) & 4'($urandom);
            for (int i = 0; i < ND; i++)
                if ($urandom % 16 == 0) drv_rdy[i] = ~drv_rdy[i];
            cyc(1);
        end
        act_stb = 1'b0;
        cyc(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule